// File: doc/BRIEF.md
# Dual-Port Parallel Interface Adapter with Handshake Lines

This block gives a CPU two 8-bit parallel ports behind four byte-wide registers. Each port holds a direction register, an output register and a six-bit control register. Software picks which of the first two appears at the port's data address by way of a control bit. Each output pin carries the output-register bit, and the direction register tells the pad logic which bits to drive. A data read returns, bit by bit, the output register where the direction bit is 1 and the live input pin where it is 0.

Each port has two handshake lines. Line 1 is always an input: its selected edge sets interrupt flag 1. Line 2 can be an input that sets flag 2 in the same way, a static output that follows a control bit, or a strobe output. The strobe output idles high and drops on a data access. On port A that access is a data read, and the line comes back high either one clock later or on the next active line-1 edge. On port B that access is a data write, and the line comes back high either one clock later or when a data read clears a pending flag 1. Each port drives one active-high interrupt output, built from its flags and their enable bits. Bus accesses are synchronous and take one cycle. Read data is combinational, and read side effects take place at the clock edge of the access.

Top module: `pario_adapter`

## Requirements
- R1: `sel` decodes as 0 = port A data, 1 = port A control, 2 = port B data, 3 = port B control. A write to one register leaves the other port's registers unchanged.
- R2: Control bit 2 chooses what the data address reaches: 0 gives the direction register and 1 gives the output register. Writes land in the selected register and show on `pX_dir` / `pX_out` in the cycle after the write.
- R3: With control bit 2 = 1, data read bit i equals output-register bit i when direction bit i is 1, and input pin bit i when direction bit i is 0.
- R4: A control read returns flag 1 in bit 7, flag 2 in bit 6 and the written control bits in bits 5..0. Writes to bits 7 and 6 do not change the flags.
- R5: A line-1 transition to the level given by control bit 1 sets flag 1: 0 selects falling and 1 selects rising. The opposite transition sets nothing.
- R6: `irq_X` = (flag1 AND control bit 0) OR (flag2 AND control bit 3). It follows flag and control changes in the cycle after they happen, so a flag that is already set raises the output when its enable bit is written.
- R7: A data read with control bit 2 = 1 clears both flags of that port. A read of the direction register clears neither.
- R8: With control bit 5 = 0, line 2 is an input (`X2_oe` = 0). A transition to the level given by bit 4 sets flag 2, and bit 3 enables it into the interrupt output.
- R9: Control bits 5..4 = 11 make line 2 a driven output (`X2_oe` = 1) equal to control bit 3 from the cycle after the control write.
- R10: Port A strobe mode (bits 5..4 = 10): `ca2_out` idles high and goes low in the cycle after a data read. With bit 3 = 1 it returns high one clock later. With bit 3 = 0 it stays low until an active line-1 edge.
- R11: Port B strobe mode (bits 5..4 = 10): `cb2_out` idles high and goes low in the cycle after a data write. With bit 3 = 1 it returns high one clock later. With bit 3 = 0 it stays low until a data read that clears a set flag 1. A line-1 edge alone does not restore it.
- R12: Synchronous reset clears all direction, output and control registers, both flags of both ports and both interrupt outputs, and leaves line 2 undriven.
- R13: If an active edge and a flag-clearing data read fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Bus access strobe |
| we | input | 1 | Write when set with `cs` |
| re | input | 1 | Read side effects when set with `cs` and `we` low |
| sel | input | 2 | Register select |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data (combinational) |
| pa_in | input | DW | Port A input pins |
| pa_out | output | DW | Port A output register |
| pa_dir | output | DW | Port A direction register (1 = drive) |
| ca1 | input | 1 | Port A line 1 |
| ca2_in | input | 1 | Port A line 2 input |
| ca2_out | output | 1 | Port A line 2 output value |
| ca2_oe | output | 1 | Port A line 2 drive enable |
| irq_a | output | 1 | Port A interrupt, active high |
| pb_in | input | DW | Port B input pins |
| pb_out | output | DW | Port B output register |
| pb_dir | output | DW | Port B direction register (1 = drive) |
| cb1 | input | 1 | Port B line 1 |
| cb2_in | input | 1 | Port B line 2 input |
| cb2_out | output | 1 | Port B line 2 output value |
| cb2_oe | output | 1 | Port B line 2 drive enable |
| irq_b | output | 1 | Port B interrupt, active high |

## Verification
The bench sweeps direction and pin patterns on both ports against the per-bit merge. A design that swapped the direction sense or read the pins through driven bits would miss there. It drives the wrong line-1 edge for each polarity to catch a design that flags any transition. It reads the direction register while a flag is pending to catch a design that clears flags on every data-address read. It also collides an active edge with a clearing read to catch a design that lets the clear win. The strobe tests mirror each port's event in the other port's style, for example a line-1 edge on port B and an early data read. They would show a design that restores port B on an edge, or one that shares a single strobe rule between the ports.

// File: rtl/pario_pkg.sv
package pario_pkg;

    // Control register bit positions
    localparam int CB_IRQ1_EN = 0;
    localparam int CB_L1_RISE = 1;
    localparam int CB_PERIPH  = 2;
    localparam int CB_L2_CTL  = 3;
    localparam int CB_L2_RISE = 4;
    localparam int CB_L2_OUT  = 5;
    localparam int CTRL_W     = 6;
    localparam int CVIEW_W    = CTRL_W + 2;

    typedef enum logic [1:0] {
        L2_INPUT  = 2'd0,
        L2_STROBE = 2'd1,
        L2_STATIC = 2'd2
    } l2_mode_e;

    typedef enum logic {
        REG_DATA = 1'b0,
        REG_CTRL = 1'b1
    } reg_kind_e;

    // sel[1] picks the port, sel[0] picks data/control
    typedef struct packed {
        logic      port_b;
        reg_kind_e kind;
    } reg_sel_t;

    // Control read layout: flag1 on top, then flag2, then written bits
    typedef struct packed {
        logic              flag1;
        logic              flag2;
        logic [CTRL_W-1:0] ctl;
    } ctrl_view_t;

    function automatic l2_mode_e l2_mode(input logic [CTRL_W-1:0] c);
        if (!c[CB_L2_OUT])      return L2_INPUT;
        else if (c[CB_L2_RISE]) return L2_STATIC;
        else                    return L2_STROBE;
    endfunction

    function automatic logic next_flag(input logic cur, input logic set_evt,
                                       input logic clr_evt);
        if (set_evt)      return 1'b1;
        else if (clr_evt) return 1'b0;
        else              return cur;
    endfunction

endpackage

// File: rtl/pario_edge.sv
module pario_edge (
    input  logic clk,
    input  logic line,
    input  logic rise_sel,
    output logic hit
);
    logic prev;

    // Sampled every cycle, including during reset, so no edge is seen on release
    always_ff @(posedge clk) begin
        prev <= line;
    end

    assign hit = (line != prev) && (line == rise_sel);
endmodule

// File: rtl/pario_port.sv
module pario_port
    import pario_pkg::*;
#(
    parameter int DW              = 8,
    parameter bit STROBE_ON_WRITE = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_data,
    input  logic          wr_ctrl,
    input  logic          rd_data,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] pin_in,
    input  logic          l1_in,
    input  logic          l2_in,
    output logic [DW-1:0] out_reg,
    output logic [DW-1:0] dir_reg,
    output logic [DW-1:0] data_rd,
    output logic [CVIEW_W-1:0] ctrl_rd,
    output logic          l2_out,
    output logic          l2_oe,
    output logic          irq
);
    logic [CTRL_W-1:0] ctl;
    logic [DW-1:0]     ora_q, ddr_q;
    logic              flag1, flag2, l2_q;
    l2_mode_e          mode, wmode;
    logic              periph, rd_periph, wr_periph;
    logic              edge1, edge2_raw, edge2;
    logic              strobe_evt, restore_evt;

    assign mode      = l2_mode(ctl);
    assign wmode     = l2_mode(wdata[CTRL_W-1:0]);
    assign periph    = ctl[CB_PERIPH];
    assign rd_periph = rd_data & periph;
    assign wr_periph = wr_data & periph;

    pario_edge u_l1_edge (
        .clk      (clk),
        .line     (l1_in),
        .rise_sel (ctl[CB_L1_RISE]),
        .hit      (edge1)
    );

    pario_edge u_l2_edge (
        .clk      (clk),
        .line     (l2_in),
        .rise_sel (ctl[CB_L2_RISE]),
        .hit      (edge2_raw)
    );

    assign edge2 = edge2_raw && (mode == L2_INPUT);

    // Register file
    always_ff @(posedge clk) begin
        if (rst) begin
            ora_q <= '0;
            ddr_q <= '0;
            ctl   <= '0;
        end else begin
            if (wr_data) begin
                if (periph) ora_q <= wdata;
                else        ddr_q <= wdata;
            end
            if (wr_ctrl) ctl <= wdata[CTRL_W-1:0];
        end
    end

    // Interrupt flags: set beats clear
    always_ff @(posedge clk) begin
        if (rst) begin
            flag1 <= 1'b0;
            flag2 <= 1'b0;
        end else begin
            flag1 <= next_flag(flag1, edge1, rd_periph);
            flag2 <= next_flag(flag2, edge2, rd_periph);
        end
    end

    // Strobe event and restore source differ per port
    generate
        if (STROBE_ON_WRITE) begin : g_wr_strobe
            assign strobe_evt  = wr_periph;
            assign restore_evt = rd_periph & flag1;
        end else begin : g_rd_strobe
            assign strobe_evt  = rd_periph;
            assign restore_evt = edge1;
        end
    endgenerate

    // Line 2 output state
    always_ff @(posedge clk) begin
        if (rst) begin
            l2_q <= 1'b1;
        end else if (wr_ctrl) begin
            l2_q <= (wmode == L2_STATIC) ? wdata[CB_L2_CTL] : 1'b1;
        end else if (mode == L2_STROBE) begin
            if (strobe_evt)
                l2_q <= 1'b0;
            else if (!l2_q && (ctl[CB_L2_CTL] || restore_evt))
                l2_q <= 1'b1;
        end
    end

    assign data_rd = periph ? ((ora_q & ddr_q) | (pin_in & ~ddr_q)) : ddr_q;
    assign ctrl_rd = ctrl_view_t'{flag1: flag1, flag2: flag2, ctl: ctl};
    assign irq     = (flag1 & ctl[CB_IRQ1_EN]) | (flag2 & ctl[CB_L2_CTL]);
    assign l2_out  = l2_q;
    assign l2_oe   = (mode != L2_INPUT);
    assign out_reg = ora_q;
    assign dir_reg = ddr_q;

    AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (rd_periph && !edge1) |=> !flag1); // R7
    AST_CTRL_WRITE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !edge1 && !rd_periph) |=> (flag1 == $past(flag1))); // R4
    AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        edge1 |=> flag1); // R13
    AST_MASK_QUIETS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !wdata[CB_IRQ1_EN] && !wdata[CB_L2_CTL]) |=> !irq); // R6
    AST_STATIC_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wdata[CB_L2_OUT] && wdata[CB_L2_RISE]) |=> (l2_out == $past(wdata[CB_L2_CTL]))); // R9
    AST_STROBE_DROPS: assert property (@(posedge clk) disable iff (rst)
        ((mode == L2_STROBE) && strobe_evt && !wr_ctrl) |=> !l2_out); // R10
endmodule

// File: rtl/pario_adapter.sv
module pario_adapter
    import pario_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs,
    input  logic          we,
    input  logic          re,
    input  logic [1:0]    sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_dir,
    input  logic          ca1,
    input  logic          ca2_in,
    output logic          ca2_out,
    output logic          ca2_oe,
    output logic          irq_a,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_dir,
    input  logic          cb1,
    input  logic          cb2_in,
    output logic          cb2_out,
    output logic          cb2_oe,
    output logic          irq_b
);
    localparam int NPORT = 2;

    reg_sel_t          rsel;
    logic              wr_acc, rd_acc;
    logic [DW-1:0]     pin_v  [NPORT];
    logic [DW-1:0]     out_v  [NPORT];
    logic [DW-1:0]     dir_v  [NPORT];
    logic [DW-1:0]     drd_v  [NPORT];
    logic [CVIEW_W-1:0] crd_v [NPORT];
    logic [NPORT-1:0]  l1_v, l2i_v, l2o_v, l2e_v, irq_v;

    assign rsel   = reg_sel_t'(sel);
    assign wr_acc = cs & we;
    assign rd_acc = cs & re & ~we;

    assign pin_v[0] = pa_in;
    assign pin_v[1] = pb_in;
    assign l1_v     = {cb1, ca1};
    assign l2i_v    = {cb2_in, ca2_in};

    generate
        for (genvar g = 0; g < NPORT; g++) begin : g_port
            localparam bit IS_B = (g == 1);
            logic hit;
            assign hit = (rsel.port_b == IS_B);

            pario_port #(
                .DW              (DW),
                .STROBE_ON_WRITE (IS_B)
            ) u_port (
                .clk     (clk),
                .rst     (rst),
                .wr_data (wr_acc & hit & (rsel.kind == REG_DATA)),
                .wr_ctrl (wr_acc & hit & (rsel.kind == REG_CTRL)),
                .rd_data (rd_acc & hit & (rsel.kind == REG_DATA)),
                .wdata   (wdata),
                .pin_in  (pin_v[g]),
                .l1_in   (l1_v[g]),
                .l2_in   (l2i_v[g]),
                .out_reg (out_v[g]),
                .dir_reg (dir_v[g]),
                .data_rd (drd_v[g]),
                .ctrl_rd (crd_v[g]),
                .l2_out  (l2o_v[g]),
                .l2_oe   (l2e_v[g]),
                .irq     (irq_v[g])
            );
        end
    endgenerate

    always_comb begin
        if (rsel.kind == REG_CTRL) rdata = DW'(crd_v[rsel.port_b]);
        else                       rdata = drd_v[rsel.port_b];
    end

    assign pa_out  = out_v[0];
    assign pa_dir  = dir_v[0];
    assign pb_out  = out_v[1];
    assign pb_dir  = dir_v[1];
    assign ca2_out = l2o_v[0];
    assign cb2_out = l2o_v[1];
    assign ca2_oe  = l2e_v[0];
    assign cb2_oe  = l2e_v[1];
    assign irq_a   = irq_v[0];
    assign irq_b   = irq_v[1];

    AST_WRITE_ISOLATION: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && !rsel.port_b) |=> (pb_out == $past(pb_out) && pb_dir == $past(pb_dir))); // R1
endmodule

// File: tb/pario_adapter_tb.sv
`timescale 1ns/1ps
module pario_adapter_tb;
    logic       clk = 1'b0;
    logic       rst, cs, we, re;
    logic [1:0] sel;
    logic [7:0] wdata, rdata, pa_in, pa_out, pa_dir, pb_in, pb_out, pb_dir;
    logic       ca1, ca2_in, ca2_out, ca2_oe, irq_a;
    logic       cb1, cb2_in, cb2_out, cb2_oe, irq_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pario_adapter #(.DW(8)) u_dut (
        .clk(clk), .rst(rst), .cs(cs), .we(we), .re(re), .sel(sel),
        .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_dir(pa_dir),
        .ca1(ca1), .ca2_in(ca2_in), .ca2_out(ca2_out), .ca2_oe(ca2_oe), .irq_a(irq_a),
        .pb_in(pb_in), .pb_out(pb_out), .pb_dir(pb_dir),
        .cb1(cb1), .cb2_in(cb2_in), .cb2_out(cb2_out), .cb2_oe(cb2_oe), .irq_b(irq_b)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); cs = 1; we = 1; re = 0; sel = a; wdata = d;
        @(negedge clk); cs = 0; we = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); cs = 1; re = 1; we = 0; sel = a;
        #1 d = rdata;
        @(negedge clk); cs = 0; re = 0;
    endtask

    task automatic set_line(input int which, input logic v);
        @(negedge clk);
        case (which)
            0: ca1 = v;
            1: ca2_in = v;
            2: cb1 = v;
            default: cb2_in = v;
        endcase
        @(negedge clk);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic irq_of(input int p);
        return p ? irq_b : irq_a;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        logic [7:0] d, dir, outv, pin;
        rst = 1; cs = 0; we = 0; re = 0; sel = 0; wdata = 0;
        pa_in = 0; pb_in = 0; ca1 = 0; ca2_in = 0; cb1 = 0; cb2_in = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R12: reset state
        check("R12 irq_a", irq_a, 0);
        check("R12 irq_b", irq_b, 0);
        check("R12 pa_out/pa_dir", {pa_out, pa_dir}, 0);
        check("R12 pb_out/pb_dir", {pb_out, pb_dir}, 0);
        check("R12 line2 oe", {ca2_oe, cb2_oe}, 0);
        rd(2'd1, d); check("R12 ctrl A", d, 8'h00);
        rd(2'd3, d); check("R12 ctrl B", d, 8'h00);
        rd(2'd0, d); check("R12 dir A", d, 8'h00);

        // R1 / R2: register map and direction/output selection
        for (int p = 0; p < 2; p++) begin
            wr(2'(2*p+1), 8'h00);
            wr(2'(2*p), 8'hF0 ^ 8'(p));
            check("R2 dir written", p ? pb_dir : pa_dir, 8'hF0 ^ 8'(p));
            wr(2'(2*p+1), 8'h04);
            wr(2'(2*p), 8'h5A + 8'(p));
            check("R2 out written", p ? pb_out : pa_out, 8'h5A + 8'(p));
            check("R2 dir kept", p ? pb_dir : pa_dir, 8'hF0 ^ 8'(p));
        end
        check("R1 port A isolated", {pa_out, pa_dir}, {8'h5A, 8'hF0});
        check("R1 port B isolated", {pb_out, pb_dir}, {8'h5B, 8'hF1});
        rd(2'd1, d); check("R1 ctrl A sel 1", d, 8'h04);

        // R3: per-bit read merge sweep
        for (int p = 0; p < 2; p++) begin
            for (int di = 0; di < 8; di++) begin
                dir  = 8'(di * 37);
                outv = 8'hC3 ^ 8'(di);
                wr(2'(2*p+1), 8'h00);
                wr(2'(2*p), dir);
                wr(2'(2*p+1), 8'h04);
                wr(2'(2*p), outv);
                for (int pi = 0; pi < 8; pi++) begin
                    pin = 8'(pi * 53 + 1);
                    @(negedge clk);
                    if (p == 0) pa_in = pin; else pb_in = pin;
                    rd(2'(2*p), d);
                    check("R3 merge", d, (outv & dir) | (pin & ~dir));
                end
            end
        end

        // R4: flag bits in control read, write-protected
        wr(2'd1, 8'h04);
        set_line(0, 1);
        set_line(0, 0);
        wr(2'd1, 8'h06);
        rd(2'd1, d); check("R4 flag kept over ctrl write", d, 8'h86);
        rd(2'd0, d);
        wr(2'd1, 8'hC4);
        rd(2'd1, d); check("R4 bits 7:6 not writable", d, 8'h04);

        // R5 / R6 / R7: edge polarity, interrupt, clear on read
        for (int p = 0; p < 2; p++) begin
            for (int pol = 0; pol < 2; pol++) begin
                set_line(p*2, 1'(pol));
                wr(2'(2*p+1), 8'h05 | 8'(pol << 1));
                rd(2'(2*p), d);
                set_line(p*2, 1'(!pol));
                rd(2'(2*p+1), d); check("R5 wrong edge ignored", d[7], 0);
                check("R6 no irq on wrong edge", irq_of(p), 0);
                set_line(p*2, 1'(pol));
                rd(2'(2*p+1), d); check("R5 active edge sets flag1", d[7], 1);
                check("R6 irq from flag1", irq_of(p), 1);
                rd(2'(2*p), d);
                check("R7 data read clears irq", irq_of(p), 0);
            end
        end

        // R6: late enable; R7: direction read does not clear
        wr(2'd1, 8'h04);
        set_line(0, 0);
        check("R6 masked flag no irq", irq_a, 0);
        wr(2'd1, 8'h05);
        check("R6 enable raises irq", irq_a, 1);
        wr(2'd1, 8'h04);
        check("R6 disable drops irq", irq_a, 0);
        wr(2'd1, 8'h01);
        check("R6 irq with direction selected", irq_a, 1);
        rd(2'd0, d);
        check("R7 direction read keeps flag", irq_a, 1);
        wr(2'd1, 8'h05);
        rd(2'd0, d);
        check("R7 data read clears", irq_a, 0);

        // R8: line 2 as input
        for (int p = 0; p < 2; p++) begin
            wr(2'(2*p+1), 8'h1C);
            check("R8 line2 not driven", p ? cb2_oe : ca2_oe, 0);
            set_line(p*2+1, 1);
            rd(2'(2*p+1), d); check("R8 rising sets flag2", d, 8'h5C);
            check("R8 irq from flag2", irq_of(p), 1);
            rd(2'(2*p), d);
            check("R7 clears flag2", irq_of(p), 0);
            wr(2'(2*p+1), 8'h0C);
            set_line(p*2+1, 0);
            rd(2'(2*p+1), d); check("R8 falling sets flag2", d, 8'h4C);
            rd(2'(2*p), d);
            set_line(p*2+1, 1);
            rd(2'(2*p+1), d); check("R8 inactive edge ignored", d, 8'h0C);
            set_line(p*2+1, 0);
            rd(2'(2*p), d);
        end

        // R13: set wins over simultaneous clear
        wr(2'd1, 8'h04);
        set_line(0, 1);
        @(negedge clk); ca1 = 0; cs = 1; re = 1; we = 0; sel = 2'd0;
        @(negedge clk); cs = 0; re = 0;
        rd(2'd1, d); check("R13 edge beats clear", d, 8'h84);
        rd(2'd0, d);

        // R9: static output
        wr(2'd1, 8'h3C);
        check("R9 A drive high", {ca2_oe, ca2_out}, 2'b11);
        wr(2'd1, 8'h34);
        check("R9 A drive low", {ca2_oe, ca2_out}, 2'b10);
        wr(2'd3, 8'h3C);
        check("R9 B drive high", {cb2_oe, cb2_out}, 2'b11);
        wr(2'd3, 8'h34);
        check("R9 B drive low", {cb2_oe, cb2_out}, 2'b10);

        // R10: port A strobe
        set_line(0, 0);
        wr(2'd1, 8'h2C);
        check("R10 idle high", {ca2_oe, ca2_out}, 2'b11);
        rd(2'd0, d);
        check("R10 read drops", ca2_out, 0);
        tick(1);
        check("R10 auto restore", ca2_out, 1);
        wr(2'd1, 8'h24);
        rd(2'd0, d);
        check("R10 read drops (edge restore)", ca2_out, 0);
        tick(3);
        check("R10 held low", ca2_out, 0);
        set_line(0, 1);
        check("R10 inactive edge keeps low", ca2_out, 0);
        set_line(0, 0);
        check("R10 active edge restores", ca2_out, 1);
        wr(2'd3, 8'h2C);
        wr(2'd2, 8'h11);
        wr(2'd1, 8'h2C);
        rd(2'd0, d);
        check("R11 port B unaffected by A", cb2_out, 1);

        // R11: port B strobe
        set_line(2, 0);
        rd(2'd2, d);
        check("R11 read does not strobe", cb2_out, 1);
        wr(2'd2, 8'h22);
        check("R11 write drops", cb2_out, 0);
        tick(1);
        check("R11 auto restore", cb2_out, 1);
        wr(2'd3, 8'h24);
        wr(2'd2, 8'h33);
        check("R11 write drops (read restore)", cb2_out, 0);
        tick(3);
        check("R11 held low", cb2_out, 0);
        rd(2'd2, d);
        check("R11 read without flag keeps low", cb2_out, 0);
        set_line(2, 1);
        set_line(2, 0);
        check("R11 edge alone keeps low", cb2_out, 0);
        rd(2'd2, d);
        check("R11 clearing read restores", cb2_out, 1);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule